// File: doc/BRIEF.md
# Residue-Channel Transposed FIR Filter

This block computes one residue lane of a fixed-coefficient FIR filter arranged in transposed form. The surrounding system splits each binary sample into residues for a set of coprime moduli. Each lane works on its own residue with no carries crossing into the other lanes, and a converter downstream rebuilds the binary result. A parameter picks the lane's modulus: 2^N-1, 2^N or 2^(N+1)-1. The residue width is N bits for the first two and N+1 bits for the third.

The coefficients are elaboration-time constants, reduced modulo the lane modulus. For every tap, the lane builds partial products only for the coefficient bits that are set. For the wrapping moduli, each partial product is a left rotation of the input residue; for the power-of-two modulus it is a truncated shift. These are reduced by a carry-save chain, merged with the next tap's stored sum in a 3:2 compressor, and resolved by a ripple-carry adder.

For the wrapping moduli, the adder's carry-out is stored beside the sum and used as the carry-in of the neighbouring tap's adder. The pair is turned into one canonical residue only once, at the output tap. For the power-of-two modulus, the carry-out is dropped at every tap.

Top module: `rns_fir_channel`

## Requirements
- R1: KIND selects the modulus: RK_LOW gives M=2^N-1 and RK_POW gives M=2^N, both with N-bit residues; RK_WIDE gives M=2^(N+1)-1 with (N+1)-bit residues. Every input code from 0 to M-1 is processed correctly.
- R2: After a rising edge at which in_valid is high, out_res equals (sum over l of COEF[l]·x[k-l]) mod M. Here x[k] is the residue just accepted, x[k-l] is the residue accepted l samples earlier, and missing history counts as 0. The result is visible in the cycle that follows that edge.
- R3: out_res is always in canonical range 0..M-1. This includes the case where the stored sum and carry add up to M or to M+1.
- R4: While in_valid is low, in_res has no effect: the tap state and out_res keep their values, and the next accepted sample continues the same history.
- R5: A synchronous active-high rst clears every tap register. out_res is 0 in the cycle after the edge at which rst is high, and the history restarts empty.
- R6: For the power-of-two modulus, carries out of the top bit are discarded at every tap. The result stays correct with maximum-valued residues at all taps.
- R7: Each COEF entry is reduced modulo M at elaboration. A coefficient equal to M acts as 0, and one larger than M acts as its remainder.
- R8: For the wrapping moduli, the end-around rotation of partial products and compressor carries, plus the carry handed between taps, keep the result exact under worst-case carries. This is shown with residue M-1 into every tap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high clear of all tap registers |
| in_valid | input | 1 | The residue on in_res is accepted at this edge |
| in_res | input | W | Input residue, 0..M-1 (W = N, or N+1 for RK_WIDE) |
| out_res | output | W | Canonical output residue of the filter lane |

## Verification
A wrong partial-product rotation or a misrouted tap carry corrupts a register in the chain. That error reaches out_res after as many accepted samples as the faulty tap sits away from the output tap, so an impulse shows each coefficient's residue within TAPS samples. A lost or doubled inter-tap carry changes the result by exactly one, which only becomes visible when carries are frequent. Long runs at maximum residues exercise this case. A broken final fold shows up at once as a non-canonical value or an off-by-M output in the same cycle.

// File: rtl/rns_fir_pkg.sv
package rns_fir_pkg;

   typedef enum int {
      RK_LOW  = 0,   // modulus 2^N - 1
      RK_POW  = 1,   // modulus 2^N
      RK_WIDE = 2    // modulus 2^(N+1) - 1
   } rns_kind_e;

   function automatic int res_width(input int n, input rns_kind_e k);
      return (k == RK_WIDE) ? n + 1 : n;
   endfunction

   function automatic int res_modulus(input int n, input rns_kind_e k);
      int w;
      w = res_width(n, k);
      return (k == RK_POW) ? (1 << w) : (1 << w) - 1;
   endfunction

   function automatic bit res_wraps(input rns_kind_e k);
      return k != RK_POW;
   endfunction

endpackage

// File: rtl/rns_pp_reduce.sv
// Constant modular multiplier: one partial product per set coefficient bit,
// reduced to a sum/carry pair by a chain of 3:2 compressors.
module rns_pp_reduce #(
   parameter int           W    = 8,
   parameter bit           WRAP = 1'b1,
   parameter logic [W-1:0] HRES = '0
) (
   input  logic [W-1:0] x,
   output logic [W-1:0] ps,
   output logic [W-1:0] pc
);

   always_comb begin : reduce
      logic [W-1:0] pp;
      logic [W-1:0] sm;
      logic [W-1:0] cy;
      logic [W-1:0] mj;
      pp = '0;
      sm = '0;
      cy = '0;
      mj = '0;
      for (int j = 0; j < W; j++) begin
         if (HRES[j]) begin
            pp = x << j;
            if (WRAP && j > 0) pp = pp | (x >> (W - j));
            mj = (sm & cy) | (sm & pp) | (cy & pp);
            sm = sm ^ cy ^ pp;
            // doubling: end-around for 2^W-1, truncated for 2^W
            cy = WRAP ? {mj[W-2:0], mj[W-1]} : {mj[W-2:0], 1'b0};
         end
      end
      ps = sm;
      pc = cy;
   end

endmodule

// File: rtl/rns_tap_accum.sv
// One tap: 3:2 compressor against the neighbour's stored sum, ripple adder
// with the neighbour's stored carry as carry-in, sum/carry registers.
module rns_tap_accum #(
   parameter int W    = 8,
   parameter bit WRAP = 1'b1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         en,
   input  logic [W-1:0] ps,
   input  logic [W-1:0] pc,
   input  logic [W-1:0] prev_s,
   input  logic         cin,
   output logic [W-1:0] s_q,
   output logic         c_q
);

   logic [W-1:0] t_s;
   logic [W-1:0] mj;
   logic [W-1:0] t_c;
   logic [W-1:0] sm;
   logic [W:0]   rc;

   assign t_s = ps ^ pc ^ prev_s;
   assign mj  = (ps & pc) | (ps & prev_s) | (pc & prev_s);

   if (WRAP) begin : g_wrap
      assign t_c = {mj[W-2:0], mj[W-1]};
   end else begin : g_trunc
      assign t_c = {mj[W-2:0], 1'b0};
   end

   assign rc[0] = WRAP ? cin : 1'b0;
   for (genvar b = 0; b < W; b++) begin : g_rca
      assign sm[b]   = t_s[b] ^ t_c[b] ^ rc[b];
      assign rc[b+1] = (t_s[b] & t_c[b]) | (t_s[b] & rc[b]) | (t_c[b] & rc[b]);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         s_q <= '0;
         c_q <= 1'b0;
      end else if (en) begin
         s_q <= sm;
         c_q <= WRAP ? rc[W] : 1'b0;
      end
   end

endmodule

// File: rtl/rns_mod_fold.sv
// Final modulo addition of the output tap's sum and carry into 0..M-1.
module rns_mod_fold #(
   parameter int W = 8,
   parameter int M = 255
) (
   input  logic [W-1:0] s,
   input  logic         c,
   output logic [W-1:0] r
);

   localparam logic [W:0] MV = (W+1)'(M);

   logic [W:0] t;
   logic [W:0] d;

   assign t = {1'b0, s} + {{W{1'b0}}, c};
   assign d = t - MV;
   assign r = (t >= MV) ? d[W-1:0] : t[W-1:0];

endmodule

// File: rtl/rns_fir_channel.sv
module rns_fir_channel
   import rns_fir_pkg::*;
#(
   parameter int          N    = 8,
   parameter rns_kind_e   KIND = RK_LOW,
   parameter int          TAPS = 16,
   parameter int unsigned COEF [TAPS] = '{3, 17, 40, 77, 120, 161, 190, 205,
                                          205, 190, 161, 120, 77, 40, 17, 3},
   localparam int          W    = res_width(N, KIND),
   localparam int          M    = res_modulus(N, KIND),
   localparam bit          WRAP = res_wraps(KIND)
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         in_valid,
   input  logic [W-1:0] in_res,
   output logic [W-1:0] out_res
);

   localparam int unsigned MU = M;

   if (N < 2 || N > 16) begin : g_bad_n
      $error("rns_fir_channel: N must lie in 2..16");
   end
   if (TAPS < 1) begin : g_bad_taps
      $error("rns_fir_channel: TAPS must be at least 1");
   end

   logic [W-1:0]    sum_q [TAPS];
   logic [TAPS-1:0] carry_q;

   for (genvar g = 0; g < TAPS; g++) begin : g_tap
      localparam logic [W-1:0] HRES = W'(COEF[g] % MU);

      logic [W-1:0] ps;
      logic [W-1:0] pc;
      logic [W-1:0] prev_s;
      logic         prev_c;

      if (g == TAPS - 1) begin : g_far
         assign prev_s = '0;
         assign prev_c = 1'b0;
      end else begin : g_link
         assign prev_s = sum_q[g+1];
         assign prev_c = carry_q[g+1];
      end

      rns_pp_reduce #(.W(W), .WRAP(WRAP), .HRES(HRES)) u_mul (
         .x  (in_res),
         .ps (ps),
         .pc (pc)
      );

      rns_tap_accum #(.W(W), .WRAP(WRAP)) u_acc (
         .clk    (clk),
         .rst    (rst),
         .en     (in_valid),
         .ps     (ps),
         .pc     (pc),
         .prev_s (prev_s),
         .cin    (prev_c),
         .s_q    (sum_q[g]),
         .c_q    (carry_q[g])
      );
   end

   rns_mod_fold #(.W(W), .M(M)) u_fold (
      .s (sum_q[0]),
      .c (carry_q[0]),
      .r (out_res)
   );

endmodule

// File: rtl/rns_fir_chk.sv
module rns_fir_chk #(
   parameter int W = 8,
   parameter int M = 255
) (
   input logic         clk,
   input logic         rst,
   input logic         in_valid,
   input logic [W-1:0] in_res,
   input logic [W-1:0] out_res
);

   localparam logic [W:0] MV = (W+1)'(M);

   AST_OUT_CANON: assert property (@(posedge clk) disable iff (rst)
      ({1'b0, out_res} < MV)); // R3

   AST_IN_CANON: assert property (@(posedge clk) disable iff (rst)
      in_valid |-> ({1'b0, in_res} < MV)); // R1

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(out_res)); // R4

   AST_RESET_CLEARS: assert property (@(posedge clk)
      rst |=> (out_res == '0)); // R5

endmodule

bind rns_fir_channel rns_fir_chk #(.W(W), .M(M)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .in_valid (in_valid),
   .in_res   (in_res),
   .out_res  (out_res)
);

// File: tb/tb_rns_fir_channel.sv
`timescale 1ns/1ps
module tb_rns_fir_channel;
   import rns_fir_pkg::*;

   localparam int TAPS = 16;
   // includes 255, 511, 300, 510, 256 to exercise reduction (R7)
   localparam int unsigned CF [TAPS] = '{255, 300, 1, 0, 511, 37, 128, 200,
                                         77, 3, 254, 510, 256, 99, 17, 64};
   localparam int MODS [3] = '{255, 256, 511};

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       vld = 1'b0;
   logic [7:0] d0 = '0;
   logic [7:0] d1 = '0;
   logic [8:0] d2 = '0;
   logic [7:0] q0;
   logic [7:0] q1;
   logic [8:0] q2;

   always #2.5 clk = ~clk;

   rns_fir_channel #(.N(8), .KIND(RK_LOW), .TAPS(TAPS), .COEF(CF)) dut (
      .clk(clk), .rst(rst), .in_valid(vld), .in_res(d0), .out_res(q0));
   rns_fir_channel #(.N(8), .KIND(RK_POW), .TAPS(TAPS), .COEF(CF)) dut_pow (
      .clk(clk), .rst(rst), .in_valid(vld), .in_res(d1), .out_res(q1));
   rns_fir_channel #(.N(8), .KIND(RK_WIDE), .TAPS(TAPS), .COEF(CF)) dut_wide (
      .clk(clk), .rst(rst), .in_valid(vld), .in_res(d2), .out_res(q2));

   int checks   = 0;
   int failures = 0;
   bit done     = 1'b0;
   int hist [3][TAPS];
   int lcg      = 12345;

   function automatic int rnd();
      lcg = lcg * 1103515245 + 12345;
      return (lcg >>> 8) & 32'h7fff;
   endfunction

   function automatic int model(input int i);
      longint acc = 0;
      for (int l = 0; l < TAPS; l++) acc += longint'(CF[l]) * longint'(hist[i][l]);
      return int'(acc % longint'(MODS[i]));
   endfunction

   function automatic int outv(input int i);
      case (i)
         0:       return int'(q0);
         1:       return int'(q1);
         default: return int'(q2);
      endcase
   endfunction

   task automatic check(input string tag, input int i, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s mod=%0d actual=%0d expected=%0d", tag, MODS[i], act, exp);
      end
   endtask

   task automatic step(input int x0, input int x1, input int x2,
                       input bit v, input bit r, input string tag);
      int xs [3];
      xs = '{x0, x1, x2};
      d0 = 8'(x0); d1 = 8'(x1); d2 = 9'(x2);
      vld = v; rst = r;
      @(posedge clk);
      #1;
      for (int i = 0; i < 3; i++) begin
         if (r) begin
            for (int l = 0; l < TAPS; l++) hist[i][l] = 0;
         end else if (v) begin
            for (int l = TAPS - 1; l > 0; l--) hist[i][l] = hist[i][l-1];
            hist[i][0] = xs[i];
         end
      end
      for (int i = 0; i < 3; i++) begin
         check(tag, i, outv(i), r ? 0 : model(i));
         check("R3", i, int'(outv(i) < MODS[i]), 1);
      end
      @(negedge clk);
   endtask

   initial begin
      for (int i = 0; i < 3; i++)
         for (int l = 0; l < TAPS; l++) hist[i][l] = 0;
      @(negedge clk);
      // reset state
      for (int k = 0; k < 3; k++) step(0, 0, 0, 1'b0, 1'b1, "R5");
      // impulse: output walks through reduced coefficients
      step(1, 1, 1, 1'b1, 1'b0, "R7");
      for (int k = 0; k < 20; k++) step(0, 0, 0, 1'b1, 1'b0, "R7");
      // every input code of each lane
      for (int v = 0; v < 511; v++) step(v % 255, v % 256, v, 1'b1, 1'b0, "R1");
      // pseudo-random stream
      for (int k = 0; k < 400; k++) begin
         int a;
         a = rnd();
         step(a % 255, rnd() % 256, (a ^ rnd()) % 511, 1'b1, 1'b0, "R2");
      end
      // worst-case carries
      for (int k = 0; k < 20; k++) step(254, 255, 510, 1'b1, 1'b0, "R8");
      for (int k = 0; k < 20; k++) step(254, 255, 510, 1'b1, 1'b0, "R6");
      // idle: inputs toggle, nothing accepted
      for (int k = 0; k < 30; k++) step(rnd() % 255, rnd() % 256, rnd() % 511, 1'b0, 1'b0, "R4");
      for (int k = 0; k < 5; k++) step(rnd() % 255, rnd() % 256, rnd() % 511, 1'b1, 1'b0, "R4");
      // mid-stream reset then fresh history
      step(7, 7, 7, 1'b1, 1'b1, "R5");
      for (int k = 0; k < 30; k++) step(rnd() % 255, rnd() % 256, rnd() % 511, 1'b1, 1'b0, "R5");
      // alternating valid gaps
      for (int k = 0; k < 60; k++) step(rnd() % 255, rnd() % 256, rnd() % 511, k[0], 1'b0, "R2");
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule